// File: doc/BRIEF.md
# Framed Record Configuration Loader

This block takes a stream of 16-bit words from an input that carries a valid strobe, finds the start of a configuration frame, splits the frame into typed records and places each record's payload into a set of capture-control registers. A frame opens with a two-word opening marker, carries any number of records in any order, and closes with a two-word closing marker. Each record starts with a one-word header: the record identifier is in the upper byte and the payload length, counted in 16-bit words, is in the lower byte.

All record payloads are written into shadow copies. The registers that drive the outputs change only when a complete frame closes. At that point they all take the shadow contents together, and a one-cycle commit strobe marks the update. A malformed frame raises an error flag and is dropped whole. The capture logic downstream therefore never sees a partly applied configuration. The trigger table record is stored as raw words and can be read back one word at a time by index.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset every register output, the decoded fields, the table read word, `commit` and `cfg_error` are all zero.
- R2: A word is taken only in a cycle with `in_valid` high, and `in_ready` is always high. While no frame is open, every word is ignored except an opening marker, and that includes a closing marker.
- R3: The opening marker is two accepted words of 0xF5A5 in a row. The closing marker is two accepted words of 0xFA5A in a row, with the first of them in a header position.
- R4: A header has the identifier in bits [15:8] and the payload word count in bits [7:0]. The known records are: identifier 0 for mode (1 word), 1 for divider (2), 3 for sample count (2), 5 for trigger position (2), 7 for global trigger (1), 8 for channel enable (1), and 0x40 for the trigger table (TBL_WORDS words, 160 by default). A 32-bit value is sent with its low word first.
- R5: Register outputs change only at commit. `commit` is high for exactly the one cycle after the second closing word is accepted, and the new values are visible in that same cycle. A register whose record is absent from a frame keeps its previous value.
- R6: The error flag is set in the cycle after the offending word is accepted. Offending words are an unknown identifier, a word count that does not match the identifier, and a lone first marker word followed by anything other than its partner. After an error the flag stays set, no commit happens, and the loader waits for the next opening marker.
- R7: An opening marker accepted anywhere after a frame has opened, including inside a record payload, throws away all shadow contents and restarts the parse at a header. It also clears the error flag.
- R8: `tbl_word` returns live trigger-table word `tbl_idx` combinationally. It returns 0 when `tbl_idx` is TBL_WORDS or greater.
- R9: The mode decode outputs are: bit 0 to `trig_en`, bit 1 to `ext_clk`, bit 2 to `clk_fall`, bit 3 to `rle_on`, bit 5 to `half_rate`, bit 6 to `quarter_rate`, bit 12 to `stream_on`, and bits 13, 14 and 15 to `test_sel[0]` (loopback), `test_sel[1]` (external) and `test_sel[2]` (internal).
- R10: The global trigger word is decoded as `stage_count` from bits [3:0] and `chan_count` from bits [15:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input stream word |
| in_ready | output | 1 | Always high |
| tbl_idx | input | 8 | Trigger table read index |
| tbl_word | output | 16 | Live trigger table word at tbl_idx |
| mode_word | output | 16 | Live mode register |
| divider | output | 32 | Live clock divider |
| sample_count | output | 32 | Live sample count |
| trig_pos | output | 32 | Live trigger position |
| trig_global | output | 16 | Live global trigger word |
| chan_enable | output | 16 | Live channel enable mask |
| trig_en | output | 1 | Mode bit 0 |
| ext_clk | output | 1 | Mode bit 1 |
| clk_fall | output | 1 | Mode bit 2 |
| rle_on | output | 1 | Mode bit 3 |
| half_rate | output | 1 | Mode bit 5 |
| quarter_rate | output | 1 | Mode bit 6 |
| stream_on | output | 1 | Mode bit 12 |
| test_sel | output | 3 | Mode bits 15:13 (internal, external, loopback) |
| stage_count | output | 4 | Trigger stage count |
| chan_count | output | 12 | Enabled channel count |
| commit | output | 1 | One-cycle strobe on frame close |
| cfg_error | output | 1 | Sticky frame error flag |

## Verification
The hardest case to reach is an opening marker that lands inside a record payload. Closely behind it is a lone marker word sitting in a header position, where the loader must defer its decision by one word. The stimulus forces both cases. It builds a payload whose words equal the opening pattern, so the restart fires mid-record. It also sends single marker words followed by an ordinary word. To show that discarded shadow writes never reach the outputs, the stimulus aborts a frame after writing a record, then sends a frame that holds nothing but the two markers. The commit that follows must reproduce the earlier live values.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int          WORD_W     = 16;
    localparam logic [15:0] SYNC_OPEN  = 16'hF5A5;
    localparam logic [15:0] SYNC_CLOSE = 16'hFA5A;

    localparam logic [7:0] ID_MODE = 8'h00;
    localparam logic [7:0] ID_DIV  = 8'h01;
    localparam logic [7:0] ID_CNT  = 8'h03;
    localparam logic [7:0] ID_TPOS = 8'h05;
    localparam logic [7:0] ID_GLB  = 8'h07;
    localparam logic [7:0] ID_CHEN = 8'h08;
    localparam logic [7:0] ID_TBL  = 8'h40;

    typedef enum logic [2:0] {
        PS_HUNT,
        PS_HDR,
        PS_PAY,
        PS_CLOSE2,
        PS_OPEN2
    } pstate_e;
endpackage

// File: rtl/cfgld_open_detect.sv
module cfgld_open_detect
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);
    typedef struct packed {
        logic              armed;
        logic [WORD_W-1:0] prev;
    } od_t;

    od_t s_d, s_q;

    assign hit_o = vld_i && s_q.armed && (s_q.prev == SYNC_OPEN) && (word_i == SYNC_OPEN);

    always_comb begin
        s_d = s_q;
        if (vld_i) begin
            if (hit_o) begin
                s_d.armed = 1'b0;
            end else begin
                s_d.armed = 1'b1;
                s_d.prev  = word_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    no_double_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/cfgld_parser.sv
module cfgld_parser
    import cfgld_pkg::*;
#(
    parameter int TBL_WORDS = 160,
    parameter int POS_W     = $clog2(TBL_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              open_hit_i,
    output logic              wr_en_o,
    output logic [7:0]        wr_id_o,
    output logic [POS_W-1:0]  wr_pos_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              reload_o,
    output logic              commit_o,
    output logic              err_o
);
    typedef struct packed {
        pstate_e          st;
        logic [7:0]       id;
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] len;
        logic             err;
    } ps_t;

    ps_t p_d, p_q;
    logic err_set;

    function automatic logic [7:0] want_len(input logic [7:0] id);
        case (id)
            ID_MODE, ID_GLB, ID_CHEN: want_len = 8'd1;
            ID_DIV, ID_CNT, ID_TPOS:  want_len = 8'd2;
            ID_TBL:                   want_len = 8'(TBL_WORDS);
            default:                  want_len = 8'd0;
        endcase
    endfunction

    always_comb begin
        p_d       = p_q;
        wr_en_o   = 1'b0;
        reload_o  = 1'b0;
        commit_o  = 1'b0;
        err_set   = 1'b0;
        wr_id_o   = p_q.id;
        wr_pos_o  = p_q.pos;
        wr_data_o = word_i;
        if (vld_i) begin
            if (open_hit_i) begin
                p_d.st   = PS_HDR;
                p_d.err  = 1'b0;
                reload_o = 1'b1;
            end else begin
                case (p_q.st)
                    PS_HUNT: ;
                    PS_HDR: begin
                        if (word_i == SYNC_CLOSE) begin
                            p_d.st = PS_CLOSE2;
                        end else if (word_i == SYNC_OPEN) begin
                            p_d.st = PS_OPEN2;
                        end else if (want_len(word_i[15:8]) != 8'd0 &&
                                     want_len(word_i[15:8]) == word_i[7:0]) begin
                            p_d.st  = PS_PAY;
                            p_d.id  = word_i[15:8];
                            p_d.pos = '0;
                            p_d.len = POS_W'(word_i[7:0]);
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                    PS_PAY: begin
                        wr_en_o = 1'b1;
                        p_d.pos = p_q.pos + 1'b1;
                        if (p_q.pos == p_q.len - 1'b1) p_d.st = PS_HDR;
                    end
                    PS_CLOSE2: begin
                        if (word_i == SYNC_CLOSE) begin
                            commit_o = 1'b1;
                            p_d.st   = PS_HUNT;
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                    PS_OPEN2: err_set = 1'b1;
                    default:  p_d.st = PS_HUNT;
                endcase
                if (err_set) begin
                    p_d.err = 1'b1;
                    p_d.st  = PS_HUNT;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{st: PS_HUNT, default: '0};
        else        p_q <= p_d;
    end

    assign err_o = p_q.err;

    // R2
    hunt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.st == PS_HUNT && !(vld_i && open_hit_i)) |=> (p_q.st == PS_HUNT));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(vld_i));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(vld_i && open_hit_i)) |=> err_o);

    // R5
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_o, reload_o, err_set, wr_en_o}));
endmodule

// File: rtl/cfgld_regbank.sv
module cfgld_regbank
    import cfgld_pkg::*;
#(
    parameter int TBL_WORDS = 160,
    parameter int POS_W     = $clog2(TBL_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_id_i,
    input  logic [POS_W-1:0]  wr_pos_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              reload_i,
    input  logic              commit_i,
    input  logic [7:0]        tbl_idx_i,
    output logic [WORD_W-1:0] tbl_word_o,
    output logic [15:0]       mode_o,
    output logic [31:0]       div_o,
    output logic [31:0]       cnt_o,
    output logic [31:0]       tpos_o,
    output logic [15:0]       glb_o,
    output logic [15:0]       chen_o,
    output logic              pulse_o
);
    typedef struct packed {
        logic [15:0]                      mode;
        logic [31:0]                      div;
        logic [31:0]                      cnt;
        logic [31:0]                      tpos;
        logic [15:0]                      glb;
        logic [15:0]                      chen;
        logic [TBL_WORDS-1:0][WORD_W-1:0] tbl;
    } bank_t;

    typedef struct packed {
        bank_t shd;
        bank_t live;
        logic  pulse;
    } rb_t;

    rb_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (reload_i) r_d.shd = r_q.live;
        if (wr_en_i) begin
            case (wr_id_i)
                ID_MODE: r_d.shd.mode = wr_data_i;
                ID_GLB:  r_d.shd.glb  = wr_data_i;
                ID_CHEN: r_d.shd.chen = wr_data_i;
                ID_DIV:  if (wr_pos_i[0]) r_d.shd.div[31:16]  = wr_data_i;
                         else             r_d.shd.div[15:0]   = wr_data_i;
                ID_CNT:  if (wr_pos_i[0]) r_d.shd.cnt[31:16]  = wr_data_i;
                         else             r_d.shd.cnt[15:0]   = wr_data_i;
                ID_TPOS: if (wr_pos_i[0]) r_d.shd.tpos[31:16] = wr_data_i;
                         else             r_d.shd.tpos[15:0]  = wr_data_i;
                ID_TBL:  if (int'(wr_pos_i) < TBL_WORDS) r_d.shd.tbl[wr_pos_i] = wr_data_i;
                default: ;
            endcase
        end
        if (commit_i) begin
            r_d.live  = r_q.shd;
            r_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_o     = r_q.live.mode;
    assign div_o      = r_q.live.div;
    assign cnt_o      = r_q.live.cnt;
    assign tpos_o     = r_q.live.tpos;
    assign glb_o      = r_q.live.glb;
    assign chen_o     = r_q.live.chen;
    assign pulse_o    = r_q.pulse;
    assign tbl_word_o = (int'(tbl_idx_i) < TBL_WORDS) ? r_q.live.tbl[tbl_idx_i] : '0;

    // R5
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(mode_o) && $stable(div_o) && $stable(cnt_o) &&
                       $stable(tpos_o) && $stable(glb_o) && $stable(chen_o)));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgld_pkg::*;
#(
    parameter int TBL_WORDS = 160
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    output logic        in_ready,
    input  logic [7:0]  tbl_idx,
    output logic [15:0] tbl_word,
    output logic [15:0] mode_word,
    output logic [31:0] divider,
    output logic [31:0] sample_count,
    output logic [31:0] trig_pos,
    output logic [15:0] trig_global,
    output logic [15:0] chan_enable,
    output logic        trig_en,
    output logic        ext_clk,
    output logic        clk_fall,
    output logic        rle_on,
    output logic        half_rate,
    output logic        quarter_rate,
    output logic        stream_on,
    output logic [2:0]  test_sel,
    output logic [3:0]  stage_count,
    output logic [11:0] chan_count,
    output logic        commit,
    output logic        cfg_error
);
    localparam int POS_W = $clog2(TBL_WORDS + 1);

    logic              open_hit, wr_en, reload, commit_now;
    logic [7:0]        wr_id;
    logic [POS_W-1:0]  wr_pos;
    logic [WORD_W-1:0] wr_data;

    assign in_ready = 1'b1;

    cfgld_open_detect u_open (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_valid),
        .word_i (in_data),
        .hit_o  (open_hit)
    );

    cfgld_parser #(.TBL_WORDS(TBL_WORDS), .POS_W(POS_W)) u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (in_valid),
        .word_i     (in_data),
        .open_hit_i (open_hit),
        .wr_en_o    (wr_en),
        .wr_id_o    (wr_id),
        .wr_pos_o   (wr_pos),
        .wr_data_o  (wr_data),
        .reload_o   (reload),
        .commit_o   (commit_now),
        .err_o      (cfg_error)
    );

    cfgld_regbank #(.TBL_WORDS(TBL_WORDS), .POS_W(POS_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_id_i    (wr_id),
        .wr_pos_i   (wr_pos),
        .wr_data_i  (wr_data),
        .reload_i   (reload),
        .commit_i   (commit_now),
        .tbl_idx_i  (tbl_idx),
        .tbl_word_o (tbl_word),
        .mode_o     (mode_word),
        .div_o      (divider),
        .cnt_o      (sample_count),
        .tpos_o     (trig_pos),
        .glb_o      (trig_global),
        .chen_o     (chan_enable),
        .pulse_o    (commit)
    );

    assign trig_en      = mode_word[0];
    assign ext_clk      = mode_word[1];
    assign clk_fall     = mode_word[2];
    assign rle_on       = mode_word[3];
    assign half_rate    = mode_word[5];
    assign quarter_rate = mode_word[6];
    assign stream_on    = mode_word[12];
    assign test_sel     = mode_word[15:13];
    assign stage_count  = trig_global[3:0];
    assign chan_count   = trig_global[15:4];

    // R8
    tbl_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tbl_idx) >= TBL_WORDS) |-> (tbl_word == 16'h0000));

    // R5
    commit_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !cfg_error);
endmodule

// File: tb/cfg_stream_loader_test.sv
module cfg_stream_loader_test;
    localparam int NT = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'h0000;
    logic        in_ready;
    logic [7:0]  tbl_idx = 8'd0;
    logic [15:0] tbl_word, mode_word, trig_global, chan_enable;
    logic [31:0] divider, sample_count, trig_pos;
    logic        trig_en, ext_clk, clk_fall, rle_on, half_rate, quarter_rate, stream_on;
    logic [2:0]  test_sel;
    logic [3:0]  stage_count;
    logic [11:0] chan_count;
    logic        commit, cfg_error;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_stream_loader uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tbl_idx(tbl_idx), .tbl_word(tbl_word),
        .mode_word(mode_word), .divider(divider), .sample_count(sample_count),
        .trig_pos(trig_pos), .trig_global(trig_global), .chan_enable(chan_enable),
        .trig_en(trig_en), .ext_clk(ext_clk), .clk_fall(clk_fall), .rle_on(rle_on),
        .half_rate(half_rate), .quarter_rate(quarter_rate), .stream_on(stream_on),
        .test_sel(test_sel), .stage_count(stage_count), .chan_count(chan_count),
        .commit(commit), .cfg_error(cfg_error)
    );

    typedef struct {
        bit          is_err;
        logic [15:0] mode;
        logic [31:0] div;
        logic [31:0] cnt;
        logic [31:0] tpos;
        logic [15:0] glb;
        logic [15:0] chen;
    } exp_t;

    exp_t        sbq[$];
    exp_t        m_live, m_shd;
    logic [15:0] t_live[NT];
    logic [15:0] t_shd[NT];

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'hF5A5;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame();
        put(16'hF5A5);
        put(16'hF5A5);
        m_shd = m_live;
        for (int i = 0; i < NT; i++) t_shd[i] = t_live[i];
    endtask

    task automatic close_frame();
        exp_t e;
        e = m_shd;
        e.is_err = 1'b0;
        sbq.push_back(e);
        m_live = m_shd;
        for (int i = 0; i < NT; i++) t_live[i] = t_shd[i];
        put(16'hFA5A);
        put(16'hFA5A);
    endtask

    task automatic push_err();
        exp_t e;
        e = m_live;
        e.is_err = 1'b1;
        sbq.push_back(e);
    endtask

    task automatic rec16(input logic [7:0] id, input logic [15:0] v);
        put({id, 8'h01});
        put(v);
        case (id)
            8'h00: m_shd.mode = v;
            8'h07: m_shd.glb  = v;
            8'h08: m_shd.chen = v;
            default: ;
        endcase
    endtask

    task automatic rec32(input logic [7:0] id, input logic [31:0] v);
        put({id, 8'h02});
        put(v[15:0]);
        put(v[31:16]);
        case (id)
            8'h01: m_shd.div  = v;
            8'h03: m_shd.cnt  = v;
            8'h05: m_shd.tpos = v;
            default: ;
        endcase
    endtask

    task automatic tbl_rec(input logic [15:0] seed);
        put(16'h40A0);
        for (int i = 0; i < NT; i++) begin
            t_shd[i] = seed + 16'(i) * 16'h0101;
            put(t_shd[i]);
        end
    endtask

    // Scoreboard monitor
    logic err_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (commit) begin
                if (sbq.size() == 0) begin
                    chk("R5", 32'd1, 32'd0, "unexpected commit");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk("R5", {31'd0, e.is_err}, 32'd0, "commit where error expected");
                    chk("R4", {16'd0, mode_word}, {16'd0, e.mode}, "mode");
                    chk("R4", divider, e.div, "divider");
                    chk("R4", sample_count, e.cnt, "count");
                    chk("R4", trig_pos, e.tpos, "trigger position");
                    chk("R4", {16'd0, trig_global}, {16'd0, e.glb}, "global");
                    chk("R4", {16'd0, chan_enable}, {16'd0, e.chen}, "channel enable");
                end
            end
            if (cfg_error && !err_prev) begin
                if (sbq.size() == 0) begin
                    chk("R6", 32'd1, 32'd0, "unexpected error");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk("R6", {31'd0, e.is_err}, 32'd1, "error where commit expected");
                end
            end
            err_prev <= cfg_error;
        end
    end

    task automatic chk_live(input string rq);
        chk(rq, {16'd0, mode_word}, {16'd0, m_live.mode}, "live mode");
        chk(rq, divider, m_live.div, "live divider");
        chk(rq, sample_count, m_live.cnt, "live count");
        chk(rq, {16'd0, chan_enable}, {16'd0, m_live.chen}, "live chen");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_live = '{1'b0, 16'h0, 32'h0, 32'h0, 32'h0, 16'h0, 16'h0};
        m_shd  = m_live;
        for (int i = 0; i < NT; i++) begin
            t_live[i] = 16'h0;
            t_shd[i]  = 16'h0;
        end
        idle(3);
        // R1 reset state
        chk("R1", {16'd0, mode_word}, 32'd0, "mode after reset");
        chk("R1", divider | sample_count | trig_pos, 32'd0, "32-bit regs after reset");
        chk("R1", {16'd0, trig_global | chan_enable | tbl_word}, 32'd0, "16-bit regs after reset");
        chk("R1", {30'd0, commit, cfg_error}, 32'd0, "strobes after reset");
        chk("R1", {20'd0, stage_count, chan_count[7:0]}, 32'd0, "decoded after reset");
        rst_n = 1'b1;
        idle(2);

        // R2: words and a closing marker with no frame open are ignored
        chk("R2", {31'd0, in_ready}, 32'd1, "ready");
        put(16'hFA5A); put(16'hFA5A); put(16'h0001); put(16'h1234);
        idle(3);
        chk_live("R2");
        chk("R2", {31'd0, cfg_error}, 32'd0, "error after hunt noise");

        // R3/R4: full frame with every record
        open_frame();
        rec16(8'h00, 16'hA06F);
        rec32(8'h01, 32'h0001_0004);
        rec32(8'h03, 32'h0010_2000);
        rec32(8'h05, 32'h0000_0400);
        rec16(8'h07, 16'h0053);
        rec16(8'h08, 16'h001F);
        tbl_rec(16'h3C00);
        close_frame();
        idle(2);
        // R9 mode decode
        chk("R9", {25'd0, trig_en, ext_clk, clk_fall, rle_on, half_rate, quarter_rate, stream_on},
            32'b1111110, "mode flags");
        chk("R9", {29'd0, test_sel}, 32'd5, "test select");
        // R10 global decode
        chk("R10", {28'd0, stage_count}, 32'd3, "stage count");
        chk("R10", {20'd0, chan_count}, 32'd5, "channel count");
        // R8 table readback
        tbl_idx = 8'd0;   #1 chk("R8", {16'd0, tbl_word}, {16'd0, t_live[0]}, "table 0");
        tbl_idx = 8'd77;  #1 chk("R8", {16'd0, tbl_word}, {16'd0, t_live[77]}, "table 77");
        tbl_idx = 8'd159; #1 chk("R8", {16'd0, tbl_word}, {16'd0, t_live[159]}, "table 159");
        tbl_idx = 8'd200; #1 chk("R8", {16'd0, tbl_word}, 32'd0, "table out of range");
        tbl_idx = 8'd0;

        // R5: partial frame keeps other registers, live holds until close
        open_frame();
        rec16(8'h00, 16'h1000);
        chk("R5", {16'd0, mode_word}, 32'h0000A06F, "mode before close");
        close_frame();
        idle(1);
        chk("R9", {31'd0, stream_on}, 32'd1, "stream flag");
        chk("R5", divider, 32'h0001_0004, "divider kept");

        // R6: unknown identifier
        open_frame();
        rec16(8'h08, 16'h00FF);
        push_err();
        put(16'h0201);
        put(16'h0101); put(16'h1234); put(16'hFA5A); put(16'hFA5A);
        idle(2);
        chk("R6", {31'd0, cfg_error}, 32'd1, "error sticky");
        chk("R6", {16'd0, chan_enable}, 32'h001F, "chen not committed");

        // R7 clears error; R6 count mismatch
        open_frame();
        chk("R7", {31'd0, cfg_error}, 32'd0, "error cleared by open");
        push_err();
        put(16'h0101);
        idle(2);

        // R6: lone close word, lone open word in header position
        open_frame();
        push_err();
        put(16'hFA5A); put(16'h0001);
        idle(1);
        open_frame();
        push_err();
        put(16'hF5A5); put(16'h0001);
        idle(1);

        // R7: opening marker inside a payload restarts the parse
        open_frame();
        rec32(8'h03, 32'h5555_6666);
        put(16'h0502);
        put(16'hF5A5);
        put(16'hF5A5);
        m_shd = m_live;
        rec16(8'h07, 16'h0081);
        close_frame();
        idle(1);
        chk("R7", sample_count, 32'h0010_2000, "count discarded by restart");

        // R7: aborted frame followed by an empty frame
        open_frame();
        rec16(8'h00, 16'h0001);
        push_err();
        put(16'h0900);
        open_frame();
        close_frame();
        idle(1);
        chk("R7", {16'd0, mode_word}, 32'h00001000, "aborted mode not committed");

        // R2: gaps in valid with noise on the data lines
        put(16'hF5A5); idle(2); put(16'hF5A5); idle(1);
        m_shd = m_live;
        put(16'h0801); idle(3); put(16'h0033); m_shd.chen = 16'h0033;
        idle(1);
        close_frame();
        idle(2);
        chk("R2", {16'd0, chan_enable}, 32'h0033, "chen after gapped frame");

        idle(3);
        chk("R5", sbq.size(), 32'd0, "pending scoreboard items");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule